// File: doc/BRIEF.md
# Debug Bus Target

This block is the per-hart endpoint on a shared debug bus. Each instance has a fixed, nonzero 6-bit identity. A bus master sends the same request to every target. The request carries an operation code, a select, a mask, a 16-bit argument and a 32-bit data word.

A target whose identity equals the select drives a response record for one cycle. The response shows:
- its own number;
- the sticky halt, breakpoint and resume events collected since the last acknowledge;
- the result of the operation.

Every field of an idle target's response is zero, so the responses of many targets can be OR-combined onto one return bus. A separate masked identity compare lets the master poll a group of targets at once. Every target in the group that holds a pending event raises attention on the next cycle.

Accepted operations act on two neighbours, modelled as ports:
- **Register file:** reads use a combinational read port; writes go out as a one-cycle write strobe.
- **Pipeline control port:** carries halt, kill-fetch and debug-return requests, and instructions or program-buffer entries to execute.

Top module: `dbg_bus_target`

## Requirements
- R1: After reset, every response output, the register-file write strobe and every pipeline control output are zero.
- R2: The target drives the response the cycle after a request whose select equals TARGET_ID, whatever the request valid bit is. Driving means rsp_valid=1 and rsp_selected=TARGET_ID. When not driving, every response field except rsp_attention is zero.
- R3: A one-cycle pulse on core_evt_halt, core_evt_bp or core_evt_resume sets a sticky flag. The flag stays set until acknowledged. Flags show on rsp_halted, rsp_bp_hit and rsp_resumed only while the target drives the response; they show the value held when the request was sampled.
- R4: A valid acknowledge (op 3) addressed to this target clears all three flags at the edge that accepts it. The response to the acknowledge still shows the flags as they were before clearing. An event pulse in the same cycle as the acknowledge leaves its flag set.
- R5: rsp_attention is high the cycle after a request where (req_mask AND TARGET_ID) == (req_mask AND req_select) and at least one flag was set. It is low otherwise. req_valid has no effect on it.
- R6: A valid read (op 1) presents req_arg[REG_IDX_W-1:0] on rf_raddr in the same cycle. The next cycle, rsp_data carries the rf_rdata value sampled at that edge.
- R7: A valid write (op 2) pulses rf_we for one cycle, the cycle after the request, with rf_waddr = req_arg[REG_IDX_W-1:0] and rf_wdata = req_data. Its rsp_data is zero.
- R8: A valid execute (op 4) with core_halted high pulses pc_valid the next cycle with pc_data = req_data and rsp_error low.
- R9: An execute (op 4) or execute-program-buffer (op 5) with core_halted low sets rsp_error the next cycle. It raises no pc_valid.
- R10: A valid execute-program-buffer (op 5) with core_halted high pulses pc_valid the next cycle, with pc_data equal to req_arg zero-extended.
- R11: A valid set-requests (op 0) pulses pc_valid the next cycle with pc_halt_req=req_arg[0], pc_kill_fetch=req_arg[1], pc_fetch_dret=req_arg[2] and pc_data zero.
- R12: When the target drives the response for a request with req_valid low, rsp_none is 1 and rsp_data and rsp_error are 0. rsp_none is 0 for a valid request.
- R13: A valid request whose select differs from TARGET_ID has no effect. It causes no rf_we and no pc_valid, and an acknowledge sent to another target leaves this target's flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request carries an operation |
| req_op | input | 3 | Operation: 0 set-requests, 1 read, 2 write, 3 acknowledge, 4 execute, 5 execute program buffer |
| req_select | input | ID_W | Target addressed by the operation |
| req_mask | input | ID_W | Mask for the attention group compare |
| req_arg | input | ARG_W | Operation argument |
| req_data | input | DATA_W | Write data or instruction word |
| core_halted | input | 1 | Hart is currently halted (level) |
| core_evt_halt | input | 1 | Halt event pulse |
| core_evt_bp | input | 1 | Breakpoint-hit event pulse |
| core_evt_resume | input | 1 | Resume event pulse |
| rf_raddr | output | REG_IDX_W | Register file read index |
| rf_rdata | input | DATA_W | Register file read data |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | REG_IDX_W | Register file write index |
| rf_wdata | output | DATA_W | Register file write data |
| pc_valid | output | 1 | Pipeline control command valid |
| pc_halt_req | output | 1 | Request halt |
| pc_kill_fetch | output | 1 | Request fetch kill |
| pc_fetch_dret | output | 1 | Request debug return |
| pc_data | output | DATA_W | Instruction or program-buffer entry to execute |
| rsp_valid | output | 1 | Target drives the response |
| rsp_attention | output | 1 | Group member with pending events |
| rsp_data | output | DATA_W | Read result, zero otherwise |
| rsp_halted | output | 1 | Halt event since last acknowledge |
| rsp_bp_hit | output | 1 | Breakpoint event since last acknowledge |
| rsp_resumed | output | 1 | Resume event since last acknowledge |
| rsp_none | output | 1 | Driven response holds no operation result |
| rsp_error | output | 1 | Execute refused because the hart is not halted |
| rsp_selected | output | ID_W | Own identity while driving, zero otherwise |

## Verification
The assertions assume the following about the block's inputs:
- Event inputs are single-cycle pulses.
- core_halted is a stable level that does not change during the cycle a request is sampled.
- At most one request is presented per cycle.

The stimulus keeps within these limits. Events are driven for exactly one cycle by the same task that drives the request. core_halted changes only at the negative edge together with the request. The register-file model answers combinationally from the index alone, so a read result depends only on the argument.

// File: rtl/dbgt_pkg.sv
package dbgt_pkg;
   typedef enum logic [2:0] {
      DOP_SET_REQ = 3'd0,
      DOP_READ    = 3'd1,
      DOP_WRITE   = 3'd2,
      DOP_ACK     = 3'd3,
      DOP_EXEC    = 3'd4,
      DOP_EXEC_PB = 3'd5
   } dop_e;

   localparam int EV_HALT   = 0;
   localparam int EV_BP     = 1;
   localparam int EV_RESUME = 2;
   localparam int EV_N      = 3;
endpackage

// File: rtl/dbgt_match.sv
module dbgt_match #(
   parameter int              ID_W      = 6,
   parameter logic [ID_W-1:0] TARGET_ID = 6'd5
) (
   input  logic [ID_W-1:0] select_i,
   input  logic [ID_W-1:0] mask_i,
   output logic            sel_hit_o,
   output logic            grp_hit_o
);
   logic [ID_W-1:0] diff;

   always_comb begin
      diff      = select_i ^ TARGET_ID;
      sel_hit_o = (diff == '0);
      grp_hit_o = ((diff & mask_i) == '0);
   end
endmodule

// File: rtl/dbgt_events.sv
module dbgt_events #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_i,
   output logic [N-1:0] flags_o
);
   for (genvar k = 0; k < N; k++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)          flags_o[k] <= 1'b0;
         else if (set_i[k])   flags_o[k] <= 1'b1;
         else if (clr_i)      flags_o[k] <= 1'b0;
      end

      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !set_i[k]) |=> !flags_o[k]);                    // R4
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_o[k] && !clr_i) |=> flags_o[k]);                   // R3
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[k] |=> flags_o[k]);                                 // R4
   end
endmodule

// File: rtl/dbgt_pipe_ctl.sv
module dbgt_pipe_ctl #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_cmd_i,
   input  logic [2:0]        req_bits_i,
   input  logic              exec_i,
   input  logic [DATA_W-1:0] exec_word_i,
   output logic              pc_valid_o,
   output logic              pc_halt_req_o,
   output logic              pc_kill_fetch_o,
   output logic              pc_fetch_dret_o,
   output logic [DATA_W-1:0] pc_data_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_valid_o      <= 1'b0;
         pc_halt_req_o   <= 1'b0;
         pc_kill_fetch_o <= 1'b0;
         pc_fetch_dret_o <= 1'b0;
         pc_data_o       <= '0;
      end else begin
         pc_valid_o      <= req_cmd_i | exec_i;
         pc_halt_req_o   <= req_cmd_i & req_bits_i[0];
         pc_kill_fetch_o <= req_cmd_i & req_bits_i[1];
         pc_fetch_dret_o <= req_cmd_i & req_bits_i[2];
         pc_data_o       <= exec_i ? exec_word_i : '0;
      end
   end

   AST_REQ_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_halt_req_o || pc_kill_fetch_o || pc_fetch_dret_o) |-> (pc_valid_o && pc_data_o == '0)); // R11
   AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_cmd_i && !exec_i) |=> !pc_valid_o);                    // R13
endmodule

// File: rtl/dbg_bus_target.sv
module dbg_bus_target
   import dbgt_pkg::*;
#(
   parameter int              ID_W      = 6,
   parameter logic [ID_W-1:0] TARGET_ID = 6'd5,
   parameter int              ARG_W     = 16,
   parameter int              DATA_W    = 32,
   parameter int              REG_IDX_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [2:0]           req_op,
   input  logic [ID_W-1:0]      req_select,
   input  logic [ID_W-1:0]      req_mask,
   input  logic [ARG_W-1:0]     req_arg,
   input  logic [DATA_W-1:0]    req_data,
   input  logic                 core_halted,
   input  logic                 core_evt_halt,
   input  logic                 core_evt_bp,
   input  logic                 core_evt_resume,
   output logic [REG_IDX_W-1:0] rf_raddr,
   input  logic [DATA_W-1:0]    rf_rdata,
   output logic                 rf_we,
   output logic [REG_IDX_W-1:0] rf_waddr,
   output logic [DATA_W-1:0]    rf_wdata,
   output logic                 pc_valid,
   output logic                 pc_halt_req,
   output logic                 pc_kill_fetch,
   output logic                 pc_fetch_dret,
   output logic [DATA_W-1:0]    pc_data,
   output logic                 rsp_valid,
   output logic                 rsp_attention,
   output logic [DATA_W-1:0]    rsp_data,
   output logic                 rsp_halted,
   output logic                 rsp_bp_hit,
   output logic                 rsp_resumed,
   output logic                 rsp_none,
   output logic                 rsp_error,
   output logic [ID_W-1:0]      rsp_selected
);
   localparam int PAD_W = (DATA_W > ARG_W) ? DATA_W - ARG_W : 1;

   if (TARGET_ID == '0) begin : g_bad_id
      $error("TARGET_ID zero is reserved for an idle bus");
   end
   if (REG_IDX_W > ARG_W) begin : g_bad_idx
      $error("REG_IDX_W must fit in the argument");
   end
   if (ARG_W > DATA_W || ARG_W < 3) begin : g_bad_arg
      $error("ARG_W must be 3..DATA_W");
   end

   logic            sel_hit, grp_hit;
   logic            acc, is_exec, exec_err, do_ack, do_read, do_write, do_req;
   logic [EV_N-1:0] ev_set, ev_flags;
   logic [DATA_W-1:0] pb_word, exec_word;

   dbgt_match #(.ID_W(ID_W), .TARGET_ID(TARGET_ID)) u_match (
      .select_i  (req_select),
      .mask_i    (req_mask),
      .sel_hit_o (sel_hit),
      .grp_hit_o (grp_hit)
   );

   if (DATA_W > ARG_W) begin : g_arg_pad
      assign pb_word = {{PAD_W{1'b0}}, req_arg};
   end else begin : g_arg_full
      assign pb_word = req_arg;
   end

   always_comb begin
      acc       = req_valid & sel_hit;
      do_read   = acc & (req_op == DOP_READ);
      do_write  = acc & (req_op == DOP_WRITE);
      do_ack    = acc & (req_op == DOP_ACK);
      do_req    = acc & (req_op == DOP_SET_REQ);
      is_exec   = acc & ((req_op == DOP_EXEC) | (req_op == DOP_EXEC_PB));
      exec_err  = is_exec & ~core_halted;
      exec_word = (req_op == DOP_EXEC) ? req_data : pb_word;
      rf_raddr  = req_arg[REG_IDX_W-1:0];
      ev_set    = '0;
      ev_set[EV_HALT]   = core_evt_halt;
      ev_set[EV_BP]     = core_evt_bp;
      ev_set[EV_RESUME] = core_evt_resume;
   end

   dbgt_events #(.N(EV_N)) u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (ev_set),
      .clr_i   (do_ack),
      .flags_o (ev_flags)
   );

   dbgt_pipe_ctl #(.DATA_W(DATA_W)) u_pipe (
      .clk             (clk),
      .rst_n           (rst_n),
      .req_cmd_i       (do_req),
      .req_bits_i      (req_arg[2:0]),
      .exec_i          (is_exec & core_halted),
      .exec_word_i     (exec_word),
      .pc_valid_o      (pc_valid),
      .pc_halt_req_o   (pc_halt_req),
      .pc_kill_fetch_o (pc_kill_fetch),
      .pc_fetch_dret_o (pc_fetch_dret),
      .pc_data_o       (pc_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_attention <= 1'b0;
         rsp_data      <= '0;
         rsp_halted    <= 1'b0;
         rsp_bp_hit    <= 1'b0;
         rsp_resumed   <= 1'b0;
         rsp_none      <= 1'b0;
         rsp_error     <= 1'b0;
         rsp_selected  <= '0;
         rf_we         <= 1'b0;
         rf_waddr      <= '0;
         rf_wdata      <= '0;
      end else begin
         rsp_valid     <= sel_hit;
         rsp_attention <= grp_hit & (|ev_flags);
         rsp_data      <= do_read ? rf_rdata : '0;
         rsp_halted    <= sel_hit & ev_flags[EV_HALT];
         rsp_bp_hit    <= sel_hit & ev_flags[EV_BP];
         rsp_resumed   <= sel_hit & ev_flags[EV_RESUME];
         rsp_none      <= sel_hit & ~req_valid;
         rsp_error     <= exec_err;
         rsp_selected  <= sel_hit ? TARGET_ID : '0;
         rf_we         <= do_write;
         rf_waddr      <= do_write ? req_arg[REG_IDX_W-1:0] : '0;
         rf_wdata      <= do_write ? req_data : '0;
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_data == '0 && rsp_selected == '0 && !rsp_halted &&
                      !rsp_bp_hit && !rsp_resumed && !rsp_none && !rsp_error)); // R2
   AST_OWN_ID: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_selected == TARGET_ID));                  // R2
   AST_ATTN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_attention |-> $past(|ev_flags));                         // R5
   AST_ERR_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |-> !pc_valid);                                    // R9
   AST_NONE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_none |-> (rsp_data == '0 && !rsp_error && !pc_valid && !rf_we)); // R12
   AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_hit |=> (!rf_we && !pc_valid));                         // R13
endmodule

// File: tb/sim_dbg_bus_target.sv
module sim_dbg_bus_target;
   localparam logic [5:0] MY_ID = 6'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [5:0]  req_select = '0, req_mask = '0;
   logic [15:0] req_arg = '0;
   logic [31:0] req_data = '0;
   logic        core_halted = 1'b0;
   logic        core_evt_halt = 1'b0, core_evt_bp = 1'b0, core_evt_resume = 1'b0;
   logic [4:0]  rf_raddr, rf_waddr;
   logic [31:0] rf_rdata, rf_wdata, pc_data, rsp_data;
   logic        rf_we, pc_valid, pc_halt_req, pc_kill_fetch, pc_fetch_dret;
   logic        rsp_valid, rsp_attention, rsp_halted, rsp_bp_hit, rsp_resumed;
   logic        rsp_none, rsp_error;
   logic [5:0]  rsp_selected;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   assign rf_rdata = {16'hC0DE, 11'd0, rf_raddr};

   dbg_bus_target #(.TARGET_ID(MY_ID)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_select(req_select), .req_mask(req_mask), .req_arg(req_arg),
      .req_data(req_data), .core_halted(core_halted),
      .core_evt_halt(core_evt_halt), .core_evt_bp(core_evt_bp),
      .core_evt_resume(core_evt_resume), .rf_raddr(rf_raddr),
      .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
      .rf_wdata(rf_wdata), .pc_valid(pc_valid), .pc_halt_req(pc_halt_req),
      .pc_kill_fetch(pc_kill_fetch), .pc_fetch_dret(pc_fetch_dret),
      .pc_data(pc_data), .rsp_valid(rsp_valid), .rsp_attention(rsp_attention),
      .rsp_data(rsp_data), .rsp_halted(rsp_halted), .rsp_bp_hit(rsp_bp_hit),
      .rsp_resumed(rsp_resumed), .rsp_none(rsp_none), .rsp_error(rsp_error),
      .rsp_selected(rsp_selected)
   );

   typedef struct packed {
      logic        valid, attn;
      logic [31:0] data;
      logic        halted, bp, resumed, none, err;
      logic [5:0]  sel;
      logic        pcv, pch, pck, pcd;
      logic [31:0] pcdata;
      logic        we;
      logic [4:0]  waddr;
      logic [31:0] wdata;
   } obs_t;

   obs_t   exp_q[$];
   string  tag_q[$];
   obs_t   obs;
   logic [2:0] m_flags = '0;

   always_comb begin
      obs = '0;
      obs.valid = rsp_valid;   obs.attn = rsp_attention; obs.data = rsp_data;
      obs.halted = rsp_halted; obs.bp = rsp_bp_hit;      obs.resumed = rsp_resumed;
      obs.none = rsp_none;     obs.err = rsp_error;      obs.sel = rsp_selected;
      obs.pcv = pc_valid;      obs.pch = pc_halt_req;    obs.pck = pc_kill_fetch;
      obs.pcd = pc_fetch_dret; obs.pcdata = pc_data;     obs.we = rf_we;
      obs.waddr = rf_waddr;    obs.wdata = rf_wdata;
   end

   task automatic check(input string tag, input obs_t got, input obs_t want);
      checks++;
      if (got !== want) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", tag, got, want);
      end
   endtask

   // driver: one request per cycle, expected result pushed to the scoreboard
   task automatic step(input string tag, input logic v, input logic [2:0] op,
                       input logic [5:0] sel, input logic [5:0] mask,
                       input logic [15:0] arg, input logic [31:0] data,
                       input logic [2:0] evt, input logic hlt);
      obs_t e;
      logic hit, acc;
      @(negedge clk);
      req_valid = v; req_op = op; req_select = sel; req_mask = mask;
      req_arg = arg; req_data = data; core_halted = hlt;
      core_evt_halt = evt[0]; core_evt_bp = evt[1]; core_evt_resume = evt[2];
      e   = '0;
      hit = (sel == MY_ID);
      acc = v && hit;
      e.attn = ((mask & MY_ID) == (mask & sel)) && (m_flags != 3'b000);
      if (hit) begin
         e.valid = 1'b1; e.sel = MY_ID; e.none = !v;
         e.halted = m_flags[0]; e.bp = m_flags[1]; e.resumed = m_flags[2];
      end
      if (acc) begin
         case (op)
            3'd0: begin e.pcv = 1'b1; e.pch = arg[0]; e.pck = arg[1]; e.pcd = arg[2]; end
            3'd1: e.data = {16'hC0DE, 11'd0, arg[4:0]};
            3'd2: begin e.we = 1'b1; e.waddr = arg[4:0]; e.wdata = data; end
            3'd4: if (hlt) begin e.pcv = 1'b1; e.pcdata = data; end else e.err = 1'b1;
            3'd5: if (hlt) begin e.pcv = 1'b1; e.pcdata = {16'd0, arg}; end else e.err = 1'b1;
            default: ;
         endcase
      end
      if (acc && op == 3'd3) m_flags = 3'b000;
      m_flags = m_flags | evt;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // monitor: compares after each edge that follows a driven request
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) check(tag_q.pop_front(), obs, exp_q.pop_front());
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R1 reset", obs, '0);
      @(negedge clk);
      rst_n = 1'b1;
      //   tag            v  op    sel    mask   arg       data          evt    hlt
      step("R2 idle",     0, 3'd0, 6'd0,  6'h3F, 16'h0,    32'h0,        3'b000, 0);
      step("R12 none",    0, 3'd1, MY_ID, 6'h3F, 16'h7,    32'h0,        3'b000, 0);
      step("R2 other",    1, 3'd1, 6'd4,  6'h3F, 16'h7,    32'h0,        3'b001, 0);
      step("R5 group",    0, 3'd0, 6'd0,  6'h00, 16'h0,    32'h0,        3'b000, 0);
      step("R5 exact",    0, 3'd0, MY_ID, 6'h3F, 16'h0,    32'h0,        3'b000, 0);
      step("R5 miss",     1, 3'd0, 6'd4,  6'h3F, 16'h0,    32'h0,        3'b000, 0);
      step("R5 masked",   0, 3'd0, 6'd4,  6'h3E, 16'h0,    32'h0,        3'b010, 0);
      step("R3 show",     0, 3'd0, MY_ID, 6'h3F, 16'h0,    32'h0,        3'b100, 0);
      step("R3 sticky",   0, 3'd0, MY_ID, 6'h00, 16'h0,    32'h0,        3'b000, 1);
      step("R6 read",     1, 3'd1, MY_ID, 6'h3F, 16'h0013, 32'h0,        3'b000, 1);
      step("R7 write",    1, 3'd2, MY_ID, 6'h3F, 16'h001A, 32'hDEADBEEF, 3'b000, 1);
      step("R8 exec",     1, 3'd4, MY_ID, 6'h3F, 16'h0,    32'h00100073, 3'b000, 1);
      step("R10 progbuf", 1, 3'd5, MY_ID, 6'h3F, 16'hBEEF, 32'h12345678, 3'b000, 1);
      step("R9 exec",     1, 3'd4, MY_ID, 6'h3F, 16'h0,    32'h00100073, 3'b000, 0);
      step("R9 progbuf",  1, 3'd5, MY_ID, 6'h3F, 16'h0003, 32'h0,        3'b000, 0);
      step("R11 req",     1, 3'd0, MY_ID, 6'h3F, 16'h0005, 32'hFFFF0000, 3'b000, 0);
      step("R11 req2",    1, 3'd0, MY_ID, 6'h3F, 16'h0002, 32'h0,        3'b000, 0);
      step("R13 write",   1, 3'd2, 6'd4,  6'h3F, 16'h0001, 32'h11111111, 3'b000, 0);
      step("R13 exec",    1, 3'd4, 6'd6,  6'h3F, 16'h0,    32'h22222222, 3'b000, 1);
      step("R13 ack",     1, 3'd3, 6'd4,  6'h3F, 16'h0,    32'h0,        3'b000, 1);
      step("R13 flags",   0, 3'd0, MY_ID, 6'h3F, 16'h0,    32'h0,        3'b000, 1);
      step("R4 ack",      1, 3'd3, MY_ID, 6'h3F, 16'h0,    32'h0,        3'b000, 1);
      step("R4 cleared",  0, 3'd0, MY_ID, 6'h3F, 16'h0,    32'h0,        3'b000, 1);
      step("R5 quiet",    0, 3'd0, 6'd0,  6'h00, 16'h0,    32'h0,        3'b010, 1);
      step("R4 ack+evt",  1, 3'd3, MY_ID, 6'h3F, 16'h0,    32'h0,        3'b001, 1);
      step("R4 evt wins", 0, 3'd0, MY_ID, 6'h3F, 16'h0,    32'h0,        3'b000, 1);
      step("R2 idle end", 0, 3'd0, 6'd0,  6'h3F, 16'h0,    32'h0,        3'b000, 1);
      while (exp_q.size() > 0) @(posedge clk);
      @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule